// File: doc/BRIEF.md
# Audio Port Control and Status Register File

This block holds the software-visible control and status registers of a serial audio port. A simple register bus (address, write strobe, write data, combinational read data) reaches two registers: a control word that configures the serial engine, and a status word that reports the engine's busy state and records FIFO error events. Each register can be written in three ways. A plain write replaces the contents. A set-alias write ORs the written ones into the register. A clear-alias write removes them. This lets software change single bits without a read-modify-write.

The control word powers up with its soft-reset and clock-gate bits set. While either bit is set, the configuration fields are frozen and read as zero. Software clears both bits through the clear alias before it configures the port. Underflow and overflow events from the engine latch in sticky status bits. Software clears these bits by writing ones to the status clear alias. The interrupt output is active while the error-interrupt enable is set and at least one sticky bit is latched.

Top module: `audio_port_regs`

## Requirements
- R1: Bits [3:2] of the byte address select the access kind: 0 replaces the register, 1 ORs in the written ones, 2 clears the written ones, and 3 is a write with no effect. Bits [1:0] are ignored. A read at any of the four offsets returns the register. The control register is at base 0x00 and the status register at base 0x10.
- R2: After hardware reset, the control register reads 0xC000_0000 (bit 31 soft reset = 1, bit 30 clock gate = 1, all else 0). The status sticky bits read 0, irq_o is 0 and cfg_o is 0.
- R3: While control bit 31 is 1, the configuration field (bits [11:0]) reads 0 and ignores writes, and FIFO events are not latched. Any write that sets bit 31 also clears the configuration field and all sticky status bits.
- R4: While control bit 30 is 1 and bit 31 is 0, the configuration field reads 0, ignores writes and keeps its stored value. The stored value reads back once bit 30 is cleared. FIFO events are not latched during this time.
- R5: While busy_i is 1, writes to configuration bits other than bit 0 (run) are ignored. Bit 0, bit 31 and bit 30 stay writable. Status bit 0 reflects busy_i.
- R6: evt_i[0] (underflow) sets status bit 1, and evt_i[1] (overflow) sets status bit 2. Each bit stays set until a 1 is written to it at the status clear alias (0x18). Plain writes (0x10) and set-alias writes (0x14) leave these bits unchanged.
- R7: If an event and a clear-alias write to the same sticky bit arrive in the same cycle, the bit stays set.
- R8: irq_o is 1 exactly when control bit 1 (error-interrupt enable) reads 1 and any sticky status bit is set. It follows the register state in the same cycle.
- R9: Addresses whose bits above bit 3 select neither register read 0, and writes to them change nothing.
- R10: cfg_o carries the configuration field as read on the bus, so it is 0 while the field is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| busy_i | input | 1 | Serial engine is transferring |
| evt_i | input | 2 | FIFO events: [0] underflow, [1] overflow |
| cfg_o | output | 12 | Configuration field to the engine |
| srst_o | output | 1 | Soft reset to the engine |
| gate_o | output | 1 | Clock gate to the engine |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
A write or an event takes effect on the rising edge that samples it. The bus read data, cfg_o and irq_o are combinational from the registers, so they change in the cycle right after that edge, with no further delay. The bench drives the bus and the events on the falling edge and releases them on the next falling edge. It then samples the outputs 1 ns later, so each check falls exactly one register stage after its stimulus. For the race case, the bench drives the event and the clear-alias write on the same falling edge. The result is then read after the single rising edge that samples both.

// File: rtl/audio_port_regs_pkg.sv
package audio_port_regs_pkg;

   typedef enum logic [1:0] {
      ACC_WRITE = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLEAR = 2'd2,
      ACC_NONE  = 2'd3
   } access_e;

   localparam int unsigned SLOT_CTRL = 0;
   localparam int unsigned SLOT_STAT = 1;

endpackage

// File: rtl/audio_port_bus_decode.sv
module audio_port_bus_decode
   import audio_port_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   output logic              ctrl_sel_o,
   output logic              stat_sel_o,
   output access_e           acc_o,
   output logic              ctrl_wr_o,
   output logic              stat_wr_o
);
   localparam int unsigned SLOT_W = ADDR_W - 4;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must leave at least one slot bit above the alias bits");
   end

   logic [SLOT_W-1:0] slot;
   logic              active;

   always_comb begin
      slot       = addr_i[ADDR_W-1:4];
      acc_o      = access_e'(addr_i[3:2]);
      ctrl_sel_o = (slot == SLOT_W'(SLOT_CTRL));
      stat_sel_o = (slot == SLOT_W'(SLOT_STAT));
      active     = wr_en_i && (acc_o != ACC_NONE);
      ctrl_wr_o  = active && ctrl_sel_o;
      stat_wr_o  = active && stat_sel_o;
   end

endmodule

// File: rtl/audio_port_ctrl_reg.sv
module audio_port_ctrl_reg
   import audio_port_regs_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CFG_W   = 12,
   parameter int unsigned RUN_BIT = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  access_e           acc_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              busy_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic              srst_o,
   output logic              gate_o,
   output logic              wipe_o,
   output logic              evt_en_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned SRST_BIT = DATA_W - 1;
   localparam int unsigned GATE_BIT = DATA_W - 2;
   localparam logic [CFG_W-1:0] RUN_MASK = CFG_W'(1) << RUN_BIT;

   if (CFG_W > DATA_W - 2) begin : g_bad_cfg
      $error("CFG_W overlaps the soft reset and clock gate bits");
   end
   if (RUN_BIT >= CFG_W) begin : g_bad_run
      $error("RUN_BIT must lie inside the configuration field");
   end

   logic             srst_q, gate_q;
   logic [CFG_W-1:0] cfg_q;
   logic             srst_nx, gate_nx;
   logic [CFG_W-1:0] cfg_wr, cfg_acc, cfg_nx, wcfg;
   logic             locked;

   always_comb begin
      wcfg    = wdata_i[CFG_W-1:0];
      srst_nx = srst_q;
      gate_nx = gate_q;
      cfg_wr  = cfg_q;
      if (wr_i) begin
         case (acc_i)
            ACC_WRITE: begin
               srst_nx = wdata_i[SRST_BIT];
               gate_nx = wdata_i[GATE_BIT];
               cfg_wr  = wcfg;
            end
            ACC_SET: begin
               srst_nx = srst_q | wdata_i[SRST_BIT];
               gate_nx = gate_q | wdata_i[GATE_BIT];
               cfg_wr  = cfg_q | wcfg;
            end
            ACC_CLEAR: begin
               srst_nx = srst_q & ~wdata_i[SRST_BIT];
               gate_nx = gate_q & ~wdata_i[GATE_BIT];
               cfg_wr  = cfg_q & ~wcfg;
            end
            default: ;
         endcase
      end
      cfg_acc = busy_i ? ((cfg_q & ~RUN_MASK) | (cfg_wr & RUN_MASK)) : cfg_wr;
      locked  = srst_q || gate_q;
      if (srst_nx)     cfg_nx = '0;
      else if (locked) cfg_nx = cfg_q;
      else             cfg_nx = cfg_acc;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         srst_q <= 1'b1;
         gate_q <= 1'b1;
         cfg_q  <= '0;
      end else begin
         srst_q <= srst_nx;
         gate_q <= gate_nx;
         cfg_q  <= cfg_nx;
      end
   end

   always_comb begin
      cfg_o             = locked ? '0 : cfg_q;
      srst_o            = srst_q;
      gate_o            = gate_q;
      wipe_o            = srst_nx;
      evt_en_o          = !locked;
      rdata_o           = '0;
      rdata_o[CFG_W-1:0] = cfg_o;
      rdata_o[SRST_BIT] = srst_q;
      rdata_o[GATE_BIT] = gate_q;
   end

   assert_srst_empties_cfg_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_q |-> (cfg_q == '0));

   assert_gate_keeps_cfg_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q && !srst_q && $past(gate_q)) |-> $stable(cfg_q));

   assert_busy_freezes_cfg_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> (srst_q || ((cfg_q & ~RUN_MASK) == $past(cfg_q & ~RUN_MASK))));

endmodule

// File: rtl/audio_port_stat_reg.sv
module audio_port_stat_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_EVT  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_EVT-1:0]  clr_i,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              evt_en_i,
   input  logic              wipe_i,
   input  logic              busy_i,
   output logic [N_EVT-1:0]  sticky_o,
   output logic [DATA_W-1:0] rdata_o
);
   if (N_EVT + 1 > DATA_W) begin : g_bad_evt
      $error("status word too narrow for the event bits");
   end

   for (genvar k = 0; k < N_EVT; k++) begin : g_evt
      logic flag_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      flag_q <= 1'b0;
         else if (wipe_i)  flag_q <= 1'b0;
         else              flag_q <= (flag_q & ~clr_i[k]) | (evt_i[k] & evt_en_i);
      end

      assign sticky_o[k] = flag_q;

      assert_event_latches_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (evt_i[k] && evt_en_i && !wipe_i) |=> flag_q);

      assert_flag_holds_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q && !clr_i[k] && !wipe_i) |=> flag_q);
   end

   always_comb begin
      rdata_o            = '0;
      rdata_o[0]         = busy_i;
      rdata_o[N_EVT:1]   = sticky_o;
   end

endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
   import audio_port_regs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CFG_W     = 12,
   parameter int unsigned N_EVT     = 2,
   parameter int unsigned RUN_BIT   = 0,
   parameter int unsigned IRQEN_BIT = 1,
   parameter bit          REG_IRQ   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              busy_i,
   input  logic [N_EVT-1:0]  evt_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic              srst_o,
   output logic              gate_o,
   output logic              irq_o
);
   if (IRQEN_BIT >= CFG_W || IRQEN_BIT == RUN_BIT) begin : g_bad_irqen
      $error("IRQEN_BIT must be a distinct bit of the configuration field");
   end

   logic              ctrl_sel, stat_sel, ctrl_wr, stat_wr;
   access_e           acc;
   logic              wipe, evt_en;
   logic [N_EVT-1:0]  clr_vec, sticky;
   logic [DATA_W-1:0] ctrl_rd, stat_rd;
   logic              irq_raw;

   audio_port_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i     (addr_i),
      .wr_en_i    (wr_en_i),
      .ctrl_sel_o (ctrl_sel),
      .stat_sel_o (stat_sel),
      .acc_o      (acc),
      .ctrl_wr_o  (ctrl_wr),
      .stat_wr_o  (stat_wr)
   );

   audio_port_ctrl_reg #(
      .DATA_W (DATA_W),
      .CFG_W  (CFG_W),
      .RUN_BIT(RUN_BIT)
   ) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ctrl_wr),
      .acc_i   (acc),
      .wdata_i (wr_data_i),
      .busy_i  (busy_i),
      .cfg_o   (cfg_o),
      .srst_o  (srst_o),
      .gate_o  (gate_o),
      .wipe_o  (wipe),
      .evt_en_o(evt_en),
      .rdata_o (ctrl_rd)
   );

   assign clr_vec = (stat_wr && acc == ACC_CLEAR) ? wr_data_i[N_EVT:1] : '0;

   audio_port_stat_reg #(
      .DATA_W(DATA_W),
      .N_EVT (N_EVT)
   ) u_stat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_vec),
      .evt_i   (evt_i),
      .evt_en_i(evt_en),
      .wipe_i  (wipe),
      .busy_i  (busy_i),
      .sticky_o(sticky),
      .rdata_o (stat_rd)
   );

   always_comb begin
      if (ctrl_sel)      rd_data_o = ctrl_rd;
      else if (stat_sel) rd_data_o = stat_rd;
      else               rd_data_o = '0;
   end

   assign irq_raw = cfg_o[IRQEN_BIT] && (|sticky);

   if (REG_IRQ) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   assert_unmapped_inert_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !ctrl_sel && !stat_sel) |=> $stable(ctrl_rd));

endmodule

// File: tb/audio_port_regs_tb.sv
module audio_port_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        busy = 1'b0;
   logic [1:0]  evt = '0;
   logic [11:0] cfg;
   logic        srst, gate, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   audio_port_regs u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .addr_i   (addr),
      .wr_en_i  (wr_en),
      .wr_data_i(wr_data),
      .rd_data_o(rd_data),
      .busy_i   (busy),
      .evt_i    (evt),
      .cfg_o    (cfg),
      .srst_o   (srst),
      .gate_o   (gate),
      .irq_o    (irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic pulse_evt(input logic [1:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
      #1;
   endtask

   task automatic t_reset;
      read_chk("R2 ctrl after reset", 8'h00, 32'hC000_0000);
      read_chk("R2 stat after reset", 8'h10, 32'h0);
      check("R2 irq after reset", {31'b0, irq}, 32'h0);
      check("R2 cfg_o after reset", {20'b0, cfg}, 32'h0);
   endtask

   task automatic t_soft_reset_lock;
      bus_write(8'h04, 32'h0000_00FF);
      read_chk("R3 cfg write ignored under soft reset", 8'h00, 32'hC000_0000);
      check("R10 cfg_o zero while locked", {20'b0, cfg}, 32'h0);
      pulse_evt(2'b11);
      read_chk("R3 events dropped under soft reset", 8'h10, 32'h0);
      bus_write(8'h08, 32'h8000_0000);
      read_chk("R3 soft reset cleared by clear alias", 8'h00, 32'h4000_0000);
      bus_write(8'h04, 32'h0000_00FF);
      read_chk("R4 cfg write ignored under gate", 8'h00, 32'h4000_0000);
      bus_write(8'h08, 32'h4000_0000);
      read_chk("R4 gate cleared", 8'h00, 32'h0);
   endtask

   task automatic t_alias;
      bus_write(8'h00, 32'h0000_00A4);
      read_chk("R1 plain write", 8'h00, 32'h0000_00A4);
      check("R10 cfg_o follows field", {20'b0, cfg}, 32'h0000_00A4);
      bus_write(8'h04, 32'h0000_0100);
      read_chk("R1 set alias", 8'h00, 32'h0000_01A4);
      bus_write(8'h08, 32'h0000_0004);
      read_chk("R1 clear alias", 8'h00, 32'h0000_01A0);
      bus_write(8'h0C, 32'h0000_0FFF);
      read_chk("R1 offset 0xC write inert", 8'h00, 32'h0000_01A0);
      read_chk("R1 read via set alias", 8'h04, 32'h0000_01A0);
      bus_write(8'h01, 32'h0000_0031);
      read_chk("R1 low address bits ignored", 8'h00, 32'h0000_0031);
   endtask

   task automatic t_gate_retain;
      bus_write(8'h04, 32'h4000_0000);
      read_chk("R4 field hidden while gated", 8'h00, 32'h4000_0000);
      check("R4 cfg_o zero while gated", {20'b0, cfg}, 32'h0);
      bus_write(8'h08, 32'h0000_0031);
      pulse_evt(2'b01);
      read_chk("R4 events dropped while gated", 8'h10, 32'h0);
      bus_write(8'h08, 32'h4000_0000);
      read_chk("R4 stored field returns", 8'h00, 32'h0000_0031);
   endtask

   task automatic t_sticky_irq;
      bus_write(8'h00, 32'h0);
      pulse_evt(2'b01);
      read_chk("R6 underflow latched", 8'h10, 32'h2);
      check("R8 no irq without enable", {31'b0, irq}, 32'h0);
      bus_write(8'h10, 32'h0);
      read_chk("R6 plain write keeps sticky", 8'h10, 32'h2);
      bus_write(8'h14, 32'h4);
      read_chk("R6 set alias keeps sticky", 8'h10, 32'h2);
      pulse_evt(2'b10);
      read_chk("R6 overflow latched", 8'h10, 32'h6);
      bus_write(8'h04, 32'h2);
      check("R8 irq with enable", {31'b0, irq}, 32'h1);
      bus_write(8'h18, 32'h2);
      read_chk("R6 clear alias drops underflow", 8'h10, 32'h4);
      check("R8 irq still pending", {31'b0, irq}, 32'h1);
      bus_write(8'h18, 32'h4);
      read_chk("R6 clear alias drops overflow", 8'h10, 32'h0);
      check("R8 irq drops", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_race;
      pulse_evt(2'b10);
      @(negedge clk);
      addr = 8'h18; wr_data = 32'h6; wr_en = 1'b1; evt = 2'b01;
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
      #1;
      read_chk("R7 event beats clear", 8'h10, 32'h2);
      check("R8 irq from raced bit", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_busy;
      busy = 1'b1;
      read_chk("R5 busy visible", 8'h10, 32'h3);
      bus_write(8'h00, 32'h0000_00F1);
      read_chk("R5 only run bit accepted", 8'h00, 32'h0000_0003);
      bus_write(8'h08, 32'h0000_0001);
      read_chk("R5 run cleared while busy", 8'h00, 32'h0000_0002);
      bus_write(8'h04, 32'h8000_0000);
      read_chk("R3 soft reset accepted while busy", 8'h00, 32'h8000_0000);
      read_chk("R3 soft reset wipes sticky", 8'h10, 32'h1);
      check("R8 irq off after soft reset", {31'b0, irq}, 32'h0);
      busy = 1'b0;
      bus_write(8'h08, 32'h8000_0000);
      read_chk("R3 field stays cleared", 8'h00, 32'h0);
   endtask

   task automatic t_unmapped;
      bus_write(8'h00, 32'h0000_0055);
      bus_write(8'h20, 32'hFFFF_FFFF);
      read_chk("R9 unmapped reads zero", 8'h20, 32'h0);
      read_chk("R9 ctrl untouched", 8'h00, 32'h0000_0055);
      read_chk("R9 stat untouched", 8'h10, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_soft_reset_lock();
      t_alias();
      t_gate_retain();
      t_sticky_irq();
      t_race();
      t_busy();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule